// File: doc/BRIEF.md
# Capture/Reload/Baud Timer

This block is a 16-bit timer/counter with one companion 16-bit holding register that serves two purposes. In capture mode, the holding register records the count when a falling edge arrives on a trigger pin. In reload mode, the holding register supplies the value the counter restarts from, either on overflow or on a trigger edge. A third mode turns the counter into a free-running divider. It reloads on every overflow and emits a one-clock pulse that a serial port can use as its bit clock.

All timing is paced by a machine-cycle strobe. In timer mode the count advances once per strobe. In counter mode it advances on falling edges of an external count pin, sampled at the strobes.

Software reaches the block through a small byte-wide register file. An overflow flag and an external-event flag are raised by hardware and cleared by software. Their OR forms the interrupt request.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00, and `ovf_flag`, `ext_flag`, `irq` and `baud_tick` are low.
- R2: With the run bit at 0, the count does not change, and trigger edges neither load the count nor set the external flag.
- R3: In timer mode (count-source bit 0) with run at 1, the count increases by one on every clock in which `cyc_stb` is high.
- R4: In counter mode (count-source bit 1), the count increases by one only on a strobe where the count pin sampled at the previous strobe was 1 and is 0 at this strobe.
- R5: In reload mode (capture-select 0, both clock selects 0), an increment from 0xFFFF loads the holding value into the count and sets the overflow flag.
- R6: In reload mode with external-enable 1, a trigger falling edge, detected the same way as in R4, loads the holding value and sets the external flag. If an overflow occurs on the same strobe, the count takes the holding value and both flags are set.
- R7: In capture mode (capture-select 1, both clock selects 0) with external-enable 1, a trigger falling edge copies the count as it stood before that strobe's increment into the holding register and sets the external flag. Counting continues. An overflow wraps the count to 0x0000, sets the overflow flag and leaves the holding register unchanged.
- R8: With external-enable 0, trigger edges have no effect on the count, the holding register or the external flag.
- R9: With either clock select at 1, the block is in baud mode. Overflow reloads from the holding register whatever the capture-select. The overflow flag is never set. Trigger edges are ignored. `baud_tick` is high for exactly the one clock after each overflowing strobe.
- R10: Both flags are set only by hardware. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A hardware set in the same clock as a clearing write leaves the flag set.
- R11: `irq` is high exactly when the overflow flag or the external flag is high.
- R12: Register map. Address 0 is control. Addresses 1 and 2 are the count low and high bytes. Addresses 3 and 4 are the holding register low and high bytes. The control bits are:
  - bit0: run
  - bit1: count-source
  - bit2: capture-select
  - bit3: external-enable
  - bit4: transmit-clock select
  - bit5: receive-clock select
  - bit6: external flag
  - bit7: overflow flag

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | Machine-cycle strobe; pins are sampled and the timer steps only when high |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | External capture/reload trigger input |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External-event flag |
| irq | output | 1 | Interrupt request, OR of the flags |
| baud_tick | output | 1 | One-clock pulse per overflow in baud mode |

## Verification
Three pairs of functions can land on the same strobe, and each is provoked and judged.

- **Capture and increment.** A trigger edge is arranged on a strobe that also increments. The check is that the holding register receives the pre-increment count while the count moves one past it.
- **Overflow and trigger reload.** In reload mode the counter is parked at 0xFFFF with the trigger high, then strobed with the trigger low. The count must equal the holding value, and both flags must be set.
- **Flag set and flag clear.** A clearing control write is issued in the same clock as an overflowing strobe. The overflow flag must read back as set.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef struct packed {
    logic ovf;
    logic ext;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic cap_sel;
    logic cnt_src;
    logic run;
  } ctrl_t;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_CNT0 = 1;
endpackage

// File: rtl/crt_edge_det.sv
module crt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic pin,
  output logic fall
);
  logic last_q, last_d;

  always_comb begin
    last_d = stb ? pin : last_q;
    fall   = stb & last_q & ~pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= last_d;
  end

  assert_fall_needs_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> stb);
endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import crt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [7:0] wdata,
  input  logic       set_ovf,
  input  logic       set_ext,
  output ctrl_t      ctrl_q
);
  ctrl_t ctrl_d;
  ctrl_t wr_view;

  always_comb begin
    wr_view = ctrl_t'(wdata);
    ctrl_d  = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.run     = wr_view.run;
      ctrl_d.cnt_src = wr_view.cnt_src;
      ctrl_d.cap_sel = wr_view.cap_sel;
      ctrl_d.ext_en  = wr_view.ext_en;
      ctrl_d.tx_sel  = wr_view.tx_sel;
      ctrl_d.rx_sel  = wr_view.rx_sel;
      ctrl_d.ovf     = ctrl_q.ovf & wr_view.ovf;
      ctrl_d.ext     = ctrl_q.ext & wr_view.ext;
    end
    ctrl_d.ovf = ctrl_d.ovf | set_ovf;
    ctrl_d.ext = ctrl_d.ext | set_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assert_ovf_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.ovf) |-> $past(set_ovf));
  assert_ext_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.ext) |-> $past(set_ext));
  assert_no_ovf_in_baud_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.rx_sel | ctrl_q.tx_sel) |-> !set_ovf);
endmodule

// File: rtl/crt_core.sv
module crt_core #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned NB   = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             run,
  input  logic             cnt_src,
  input  logic             cap_sel,
  input  logic             ext_en,
  input  logic             baud,
  input  logic             cnt_fall,
  input  logic             trig_fall,
  input  logic [NB-1:0]    cnt_we,
  input  logic [NB-1:0]    hold_we,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] hold_q,
  output logic             ovf_set,
  output logic             ext_set,
  output logic             baud_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_d, hold_d;
  logic             inc, ovf, trig_ok, cap, rld_trig, baud_d;

  always_comb begin
    inc      = run & (cnt_src ? cnt_fall : stb);
    ovf      = inc & (&cnt_q);
    trig_ok  = run & ext_en & trig_fall & ~baud;
    cap      = trig_ok & cap_sel;
    rld_trig = trig_ok & ~cap_sel;
    ovf_set  = ovf & ~baud;
    ext_set  = trig_ok;
    baud_d   = ovf & baud;

    cnt_d = cnt_q;
    if (ovf)           cnt_d = (baud | ~cap_sel) ? hold_q : '0;
    else if (rld_trig) cnt_d = hold_q;
    else if (inc)      cnt_d = cnt_q + ONE;
    for (int b = 0; b < NB; b++)
      if (cnt_we[b]) cnt_d[b*8 +: 8] = wdata;

    hold_d = hold_q;
    if (cap) hold_d = cnt_q;
    else
      for (int b = 0; b < NB; b++)
        if (hold_we[b]) hold_d[b*8 +: 8] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      baud_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      baud_q <= baud_d;
    end
  end

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && cnt_we == '0) |=> $stable(cnt_q));
  assert_hold_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(trig_fall && ext_en && run && cap_sel && !baud) && hold_we == '0) |=> $stable(hold_q));
  assert_tick_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_q |-> $past(baud && run));
  assert_ext_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> !ext_set);
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic              irq,
  output logic              baud_tick
);
  localparam int unsigned NB = CNT_W / 8;

  ctrl_t            ctrl_q;
  logic             cnt_fall, trig_fall, ovf_set, ext_set, wr_ctrl;
  logic [NB-1:0]    cnt_we, hold_we;
  logic [CNT_W-1:0] cnt_q, hold_q;

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
    for (int b = 0; b < NB; b++) begin
      cnt_we[b]  = reg_wr && (reg_addr == ADDR_W'(ADDR_CNT0 + b));
      hold_we[b] = reg_wr && (reg_addr == ADDR_W'(ADDR_CNT0 + NB + b));
    end
  end

  crt_edge_det u_cnt_edge (
    .clk(clk), .rst_n(rst_n), .stb(cyc_stb), .pin(cnt_pin), .fall(cnt_fall));
  crt_edge_det u_trig_edge (
    .clk(clk), .rst_n(rst_n), .stb(cyc_stb), .pin(trig_pin), .fall(trig_fall));

  crt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(reg_wdata),
    .set_ovf(ovf_set), .set_ext(ext_set), .ctrl_q(ctrl_q));

  crt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .stb(cyc_stb),
    .run(ctrl_q.run), .cnt_src(ctrl_q.cnt_src), .cap_sel(ctrl_q.cap_sel),
    .ext_en(ctrl_q.ext_en), .baud(ctrl_q.rx_sel | ctrl_q.tx_sel),
    .cnt_fall(cnt_fall), .trig_fall(trig_fall),
    .cnt_we(cnt_we), .hold_we(hold_we), .wdata(reg_wdata),
    .cnt_q(cnt_q), .hold_q(hold_q),
    .ovf_set(ovf_set), .ext_set(ext_set), .baud_q(baud_tick));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_CTRL)) reg_rdata = ctrl_q;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == ADDR_W'(ADDR_CNT0 + b))      reg_rdata = cnt_q[b*8 +: 8];
      if (reg_addr == ADDR_W'(ADDR_CNT0 + NB + b)) reg_rdata = hold_q[b*8 +: 8];
    end
    ovf_flag = ctrl_q.ovf;
    ext_flag = ctrl_q.ext;
    irq      = ctrl_q.ovf | ctrl_q.ext;
  end

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ovf_set || ext_set));
endmodule

// File: tb/cap_reload_timer_tb.sv
module cap_reload_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_stb = 0, cnt_pin = 0, trig_pin = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic ovf_flag, ext_flag, irq, baud_tick;
  int total = 0, fails = 0;
  bit done = 0;

  localparam logic [7:0] RUN = 8'h01, CNT = 8'h02, CAP = 8'h04, EXEN = 8'h08,
                         TX = 8'h10, RX = 8'h20, EXT = 8'h40, OVF = 8'h80;

  always #10 clk = ~clk;

  cap_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .cnt_pin(cnt_pin),
    .trig_pin(trig_pin), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .irq(irq), .baud_tick(baud_tick));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]); wr(a + 3'd1, d[15:8]);
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a; #1 v[7:0] = reg_rdata;
    reg_addr = a + 3'd1; #1 v[15:8] = reg_rdata;
  endtask

  task automatic rd8(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic stb(input logic c, input logic t);
    cyc_stb = 1; cnt_pin = c; trig_pin = t;
    @(posedge clk); @(negedge clk);
    cyc_stb = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, e;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin rd8(3'(a), b); chk("R1 reg", b, 0); end
    chk("R1 flags", {ovf_flag, ext_flag, irq, baud_tick}, 0);

    // R2 run=0: no count, trigger ignored
    wr(0, EXEN | CAP);
    stb(0, 1); stb(0, 0); stb(0, 0);
    rd16(1, v); chk("R2 count", v, 0);
    rd16(3, v); chk("R2 hold", v, 0);
    chk("R2 ext", ext_flag, 0);

    // R3/R5 timer sweep through overflow with reload
    wr16(3, 16'hFFF0); wr16(1, 16'hFFFC); wr(0, RUN);
    e = 16'hFFFC;
    for (int i = 0; i < 20; i++) begin
      stb(0, 0);
      e = (e == 16'hFFFF) ? 16'hFFF0 : e + 16'd1;
      rd16(1, v); chk("R3/R5 count", v, e);
    end
    chk("R5 ovf", ovf_flag, 1);
    chk("R11 irq", irq, 1);

    // R10 clear by writing 0, writing 1 does not set
    wr(0, RUN); chk("R10 clear", ovf_flag, 0);
    wr(0, RUN | OVF | EXT); chk("R10 w1 ovf", ovf_flag, 0);
    chk("R10 w1 ext", ext_flag, 0); chk("R11 irq low", irq, 0);
    rd8(0, b); chk("R12 ctrl", b, RUN);
    // R10 hardware set beats same-clock clear
    wr16(1, 16'hFFFF);
    cyc_stb = 1; reg_wr = 1; reg_addr = 0; reg_wdata = RUN;
    @(posedge clk); @(negedge clk);
    cyc_stb = 0; reg_wr = 0;
    chk("R10 set wins", ovf_flag, 1);
    wr(0, RUN);

    // R8 external enable off
    wr16(1, 16'h0100);
    stb(0, 1); stb(0, 0);
    rd16(1, v); chk("R8 count", v, 16'h0102);
    chk("R8 ext", ext_flag, 0);

    // R6 trigger reload
    wr(0, RUN | EXEN);
    stb(0, 1); stb(0, 0);
    rd16(1, v); chk("R6 reload", v, 16'hFFF0);
    chk("R6 ext", ext_flag, 1); chk("R11 irq ext", irq, 1);
    // R6 overflow and trigger same strobe
    wr(0, RUN | EXEN); wr16(3, 16'h1357);
    stb(0, 1); wr16(1, 16'hFFFF); stb(0, 0);
    rd16(1, v); chk("R6 both count", v, 16'h1357);
    chk("R6 both flags", {ovf_flag, ext_flag}, 2'b11);

    // R7 capture takes pre-increment count
    wr(0, RUN | EXEN | CAP); wr16(1, 16'h1234);
    stb(0, 1); stb(0, 0);
    rd16(3, v); chk("R7 hold", v, 16'h1235);
    rd16(1, v); chk("R7 count", v, 16'h1236);
    chk("R7 ext", ext_flag, 1);
    wr(0, RUN | EXEN | CAP); wr16(1, 16'hFFFF); stb(0, 0);
    rd16(1, v); chk("R7 wrap", v, 0);
    rd16(3, v); chk("R7 hold kept", v, 16'h1235);
    chk("R7 ovf", ovf_flag, 1);

    // R9 baud mode with each clock select
    for (int s = 0; s < 3; s++) begin
      logic [7:0] sel;
      sel = (s == 0) ? TX : (s == 1) ? RX : (TX | RX);
      wr(0, RUN | CAP | EXEN | sel);
      wr16(3, 16'hFFFE); wr16(1, 16'hFFFF);
      stb(0, 1);
      rd16(1, v); chk("R9 reload", v, 16'hFFFE);
      chk("R9 tick", baud_tick, 1);
      chk("R9 no ovf", ovf_flag, 0);
      @(negedge clk); chk("R9 tick width", baud_tick, 0);
      stb(0, 0);
      rd16(1, v); chk("R9 trig ignored", v, 16'hFFFF);
      rd16(3, v); chk("R9 hold", v, 16'hFFFE);
      chk("R9 ext", ext_flag, 0);
    end

    // R4 counter mode sweep
    wr(0, RUN | CNT); wr16(1, 0);
    begin
      logic [15:0] pat;
      logic prev;
      pat = 16'b1010_1100_1110_0110;
      prev = 0; e = 0;
      for (int i = 0; i < 16; i++) begin
        stb(pat[i], 0);
        if (prev && !pat[i]) e = e + 16'd1;
        prev = pat[i];
        rd16(1, v); chk("R4 count", v, e);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule